// File: doc/BRIEF.md
# Memory Traffic Instruction Sequencer

This block steps through a small programmable program of traffic instructions and turns each one into a stream of read and write command slots for a memory user interface. Software fills the instruction table through a level-sensitive write port while the block is idle. Each slot holds five things:

- the address and data pattern selectors;
- the read/write mode and its submode;
- the victim/aggressor settings;
- a command count and an idle-spacing rule;
- a pointer to the following slot.

A start pulse launches execution at slot 0. Slots chain through their pointers until one points at the exit encoding. When the direct-select input is high, each fetch takes the instruction from the live input fields instead of the table.

Each command slot is marked by `cmdValid`, and `cmdIsWrite` gives its direction. The fields of the active instruction are presented on the outputs so that the downstream address and data generators can follow it. The `done` flag rises when traffic ends and stays high until the next start. Address and data generation, data checking and the memory controller are not part of this block.

Top module: `mem_traffic_sequencer`

## Requirements
- R1: After reset `cmdValid` and `done` are 0, and the block waits for `start`.
- R2: While `progEn` is high and the block is idle, the input fields are written into table slot `progIdx` on every clock edge. A write attempted while traffic runs leaves the table unchanged.
- R3: A `start` pulse seen while idle clears `done` and fetches slot 0. Exactly one fetch cycle, with `cmdValid` low, comes before the first command of every instruction.
- R4: Read/write mode value 0 issues `iterCount` reads (`cmdIsWrite`=0). Mode value 1 issues `iterCount` writes (`cmdIsWrite`=1).
- R5: Mode value 2 with submode value 0 issues `iterCount` writes and then `iterCount` reads.
- R6: Mode value 2 with submode value 1 issues `iterCount` writes and `iterCount` reads in a pseudo-random interleave. At no point has the number of reads issued exceeded the number of writes issued.
- R7: Mode value 3 issues `iterCount` writes and then issues reads without end, until reset.
- R8: After every `burstN` commands of an instruction, `nopM` cycles without a command follow. No idle gap follows the instruction's last command. `burstN`=0 or `nopM`=0 disables the gaps.
- R9: After an instruction's last command, a `nextInstr` value with bit 5 clear selects the slot fetched next (bits 4:0). A value with bit 5 set ends traffic: `done` is 1 and `cmdValid` is 0 from the following cycle.
- R10: A fetched instruction with a mode value of 4 to 15, or with `iterCount`=0, acts as exit. It issues no command, and `done` rises the cycle after the fetch.
- R11: With `directEn`=1 at a fetch, the live input fields are used instead of the table.
- R12: During each command cycle the `cur*` outputs show the fields of the instruction being executed.
- R13: A `start` pulse while traffic runs has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin traffic at slot 0 (pulse, accepted when idle) |
| directEn | input | 1 | 1: fetch from input fields, 0: fetch from table |
| progEn | input | 1 | Level-sensitive table write enable |
| progIdx | input | 5 | Table slot to write |
| inAddrMode | input | 4 | Address pattern selector field |
| inDataMode | input | 4 | Data pattern selector field |
| inRwMode | input | 4 | Read/write mode field |
| inRwSub | input | 2 | Read/write submode field |
| inVictimMode | input | 3 | Aggressor behaviour field |
| inVictimDelay | input | 5 | Victim/aggressor delay field |
| inVictimSel | input | 3 | Victim bit selection field |
| inIterCount | input | 32 | Command count field |
| inBurstN | input | 32 | Commands between idle gaps |
| inNopM | input | 10 | Length of each idle gap |
| inNextInstr | input | 6 | Next slot pointer, bit 5 = exit |
| cmdValid | output | 1 | A command is issued this cycle |
| cmdIsWrite | output | 1 | 1 write, 0 read (meaningful with cmdValid) |
| done | output | 1 | Traffic has ended |
| curAddrMode | output | 4 | Active instruction address selector |
| curDataMode | output | 4 | Active instruction data selector |
| curRwMode | output | 4 | Active instruction read/write mode |
| curRwSub | output | 2 | Active instruction submode |
| curVictimMode | output | 3 | Active instruction aggressor behaviour |
| curVictimDelay | output | 5 | Active instruction delay |
| curVictimSel | output | 3 | Active instruction victim selection |

## Verification
The bench targets four kinds of corner case:

- **Idle-gap boundaries.** The bench covers a gap that falls between the write phase and the read phase, and the case where the gap would land on an instruction's last command. A design that counted gaps per phase, or that padded after the final command, would shift every later command by whole cycles.
- **Mixed interleave.** It checks the running read-not-ahead-of-write bound and the equal totals. An unguarded random choice would issue a read before its write.
- **Rejection at fetch.** It covers a zero count and a reserved mode. A design that ran such an entry would issue commands where none are due.
- **Ignored inputs.** Table writes and start pulses are sent mid-run. A design that accepted them would replay a different second instruction, or restart at slot 0.

// File: rtl/trfseq_pkg.sv
package trfseq_pkg;
  localparam int MODE_W  = 4;
  localparam int SUB_W   = 2;
  localparam int VMODE_W = 3;
  localparam int VDLY_W  = 5;
  localparam int VSEL_W  = 3;
  localparam int CNT_W   = 32;
  localparam int NOP_W   = 10;
  localparam int NEXT_W  = 6;

  localparam logic [MODE_W-1:0] RW_RD     = 4'd0;
  localparam logic [MODE_W-1:0] RW_WR     = 4'd1;
  localparam logic [MODE_W-1:0] RW_WRRD   = 4'd2;
  localparam logic [MODE_W-1:0] RW_FOREVR = 4'd3;
  localparam logic [SUB_W-1:0]  SUB_MIX   = 2'd1;

  typedef struct packed {
    logic [MODE_W-1:0]  addrMode;
    logic [MODE_W-1:0]  dataMode;
    logic [MODE_W-1:0]  rwMode;
    logic [SUB_W-1:0]   rwSub;
    logic [VMODE_W-1:0] victimMode;
    logic [VDLY_W-1:0]  victimDelay;
    logic [VSEL_W-1:0]  victimSel;
    logic [CNT_W-1:0]   iterCount;
    logic [CNT_W-1:0]   burstN;
    logic [NOP_W-1:0]   nopM;
    logic [NEXT_W-1:0]  nextInstr;
  } instr_t;

  typedef struct packed {
    logic restart;
    logic load;
    logic issue;
    logic nopTick;
    logic advance;
  } strobe_t;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_RUN} state_t;
endpackage

// File: rtl/trfseq_dp.sv
module trfseq_dp
  import trfseq_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          st,
  input  logic             idle,
  input  logic             directEn,
  input  logic             progEn,
  input  logic [IDX_W-1:0] progIdx,
  input  instr_t           progInstr,
  output instr_t           cur,
  output logic             srcValid,
  output logic             nopActive,
  output logic             lastCmd,
  output logic             nextExit,
  output logic             cmdIsWrite
);
  localparam int LFSR_W = 16;

  instr_t               tbl [ENTRIES];
  instr_t               src;
  logic [IDX_W-1:0]     ptr;
  logic [CNT_W-1:0]     wrCnt, rdCnt, burstCnt;
  logic [NOP_W-1:0]     nopCnt;
  logic [LFSR_W-1:0]    lfsr;
  logic [CNT_W:0]       wrAfter, rdAfter, iterExt;
  logic                 burstHit;

  // table writes only land while no traffic runs (R2)
  always_ff @(posedge clk) begin
    if (progEn && idle) tbl[progIdx] <= progInstr;
  end

  always_comb begin
    src      = directEn ? progInstr : tbl[ptr];
    srcValid = (src.rwMode <= RW_FOREVR) && (src.iterCount != '0);
  end

  // direction of the next command slot
  always_comb begin
    unique case (cur.rwMode)
      RW_RD:   cmdIsWrite = 1'b0;
      RW_WR:   cmdIsWrite = 1'b1;
      RW_WRRD: begin
        if (cur.rwSub == SUB_MIX) begin
          if (wrCnt == cur.iterCount)  cmdIsWrite = 1'b0;
          else if (rdCnt == wrCnt)     cmdIsWrite = 1'b1;
          else                         cmdIsWrite = lfsr[0];
        end else begin
          cmdIsWrite = (wrCnt != cur.iterCount);
        end
      end
      default: cmdIsWrite = (wrCnt != cur.iterCount);
    endcase
  end

  always_comb begin
    iterExt  = {1'b0, cur.iterCount};
    wrAfter  = {1'b0, wrCnt} + {{CNT_W{1'b0}}, cmdIsWrite};
    rdAfter  = {1'b0, rdCnt} + {{CNT_W{1'b0}}, ~cmdIsWrite};
    unique case (cur.rwMode)
      RW_RD:   lastCmd = (rdAfter == iterExt);
      RW_WR:   lastCmd = (wrAfter == iterExt);
      RW_WRRD: lastCmd = (wrAfter == iterExt) && (rdAfter == iterExt);
      default: lastCmd = 1'b0;
    endcase
    burstHit  = (cur.burstN != '0) && (({1'b0, burstCnt} + 1'b1) == {1'b0, cur.burstN});
    nopActive = (nopCnt != '0);
    nextExit  = cur.nextInstr[NEXT_W-1];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur      <= '0;
      ptr      <= '0;
      wrCnt    <= '0;
      rdCnt    <= '0;
      burstCnt <= '0;
      nopCnt   <= '0;
      lfsr     <= 16'hACE1;
    end else begin
      lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (st.restart)      ptr <= '0;
      else if (st.advance) ptr <= cur.nextInstr[IDX_W-1:0];
      if (st.load) begin
        cur      <= src;
        wrCnt    <= '0;
        rdCnt    <= '0;
        burstCnt <= '0;
        nopCnt   <= '0;
      end else if (st.issue) begin
        wrCnt <= wrAfter[CNT_W-1:0];
        rdCnt <= rdAfter[CNT_W-1:0];
        if (!lastCmd && burstHit) begin
          burstCnt <= '0;
          nopCnt   <= cur.nopM;
        end else begin
          burstCnt <= burstCnt + 1'b1;
        end
      end else if (st.nopTick) begin
        nopCnt <= nopCnt - 1'b1;
      end
    end
  end

  p_rd_behind_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st.issue && cur.rwMode == RW_WRRD && !cmdIsWrite |-> rdCnt < wrCnt);
  p_count_nonzero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st.issue |-> cur.iterCount != '0);
  p_gap_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    st.issue && !lastCmd && burstHit && cur.nopM != '0 |=> nopActive && !st.issue);
endmodule

// File: rtl/trfseq_ctrl.sv
module trfseq_ctrl
  import trfseq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start,
  input  logic    srcValid,
  input  logic    nopActive,
  input  logic    lastCmd,
  input  logic    nextExit,
  output strobe_t st,
  output logic    idle,
  output logic    done
);
  state_t state, stateNxt;

  always_comb begin
    st       = '0;
    stateNxt = state;
    unique case (state)
      S_IDLE: if (start) begin
        st.restart = 1'b1;
        stateNxt   = S_FETCH;
      end
      S_FETCH: begin
        st.load  = srcValid;
        stateNxt = srcValid ? S_RUN : S_IDLE;
      end
      default: begin
        if (nopActive) begin
          st.nopTick = 1'b1;
        end else begin
          st.issue = 1'b1;
          if (lastCmd) begin
            st.advance = !nextExit;
            stateNxt   = nextExit ? S_IDLE : S_FETCH;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= stateNxt;
      if (st.restart)
        done <= 1'b0;
      else if ((state == S_FETCH && !srcValid) || (st.issue && lastCmd && nextExit))
        done <= 1'b1;
    end
  end

  assign idle = (state == S_IDLE);

  p_exit_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    st.issue && lastCmd && nextExit |=> done && idle && !st.issue);
  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !st.issue);
  p_start_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    idle && start |=> !st.issue && !done);
  p_reject_r10: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_FETCH && !srcValid |=> done && idle);
endmodule

// File: rtl/mem_traffic_sequencer.sv
module mem_traffic_sequencer
  import trfseq_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               directEn,
  input  logic               progEn,
  input  logic [IDX_W-1:0]   progIdx,
  input  logic [MODE_W-1:0]  inAddrMode,
  input  logic [MODE_W-1:0]  inDataMode,
  input  logic [MODE_W-1:0]  inRwMode,
  input  logic [SUB_W-1:0]   inRwSub,
  input  logic [VMODE_W-1:0] inVictimMode,
  input  logic [VDLY_W-1:0]  inVictimDelay,
  input  logic [VSEL_W-1:0]  inVictimSel,
  input  logic [CNT_W-1:0]   inIterCount,
  input  logic [CNT_W-1:0]   inBurstN,
  input  logic [NOP_W-1:0]   inNopM,
  input  logic [NEXT_W-1:0]  inNextInstr,
  output logic               cmdValid,
  output logic               cmdIsWrite,
  output logic               done,
  output logic [MODE_W-1:0]  curAddrMode,
  output logic [MODE_W-1:0]  curDataMode,
  output logic [MODE_W-1:0]  curRwMode,
  output logic [SUB_W-1:0]   curRwSub,
  output logic [VMODE_W-1:0] curVictimMode,
  output logic [VDLY_W-1:0]  curVictimDelay,
  output logic [VSEL_W-1:0]  curVictimSel
);
  strobe_t st;
  instr_t  inInstr, cur;
  logic    idle, srcValid, nopActive, lastCmd, nextExit, dpIsWrite;

  assign inInstr = '{addrMode: inAddrMode, dataMode: inDataMode, rwMode: inRwMode,
                     rwSub: inRwSub, victimMode: inVictimMode, victimDelay: inVictimDelay,
                     victimSel: inVictimSel, iterCount: inIterCount, burstN: inBurstN,
                     nopM: inNopM, nextInstr: inNextInstr};

  trfseq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .srcValid(srcValid),
    .nopActive(nopActive), .lastCmd(lastCmd), .nextExit(nextExit),
    .st(st), .idle(idle), .done(done)
  );

  trfseq_dp #(.ENTRIES(ENTRIES)) u_dp (
    .clk(clk), .rst_n(rst_n), .st(st), .idle(idle), .directEn(directEn),
    .progEn(progEn), .progIdx(progIdx), .progInstr(inInstr), .cur(cur),
    .srcValid(srcValid), .nopActive(nopActive), .lastCmd(lastCmd),
    .nextExit(nextExit), .cmdIsWrite(dpIsWrite)
  );

  assign cmdValid       = st.issue;
  assign cmdIsWrite     = st.issue & dpIsWrite;
  assign curAddrMode    = cur.addrMode;
  assign curDataMode    = cur.dataMode;
  assign curRwMode      = cur.rwMode;
  assign curRwSub       = cur.rwSub;
  assign curVictimMode  = cur.victimMode;
  assign curVictimDelay = cur.victimDelay;
  assign curVictimSel   = cur.victimSel;
endmodule

// File: tb/mem_traffic_sequencer_tb.sv
module mem_traffic_sequencer_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, directEn = 1'b0, progEn = 1'b0;
  logic [4:0]  progIdx = '0;
  logic [3:0]  inAddrMode = '0, inDataMode = '0, inRwMode = '0;
  logic [1:0]  inRwSub = '0;
  logic [2:0]  inVictimMode = '0, inVictimSel = '0;
  logic [4:0]  inVictimDelay = '0;
  logic [31:0] inIterCount = '0, inBurstN = '0;
  logic [9:0]  inNopM = '0;
  logic [5:0]  inNextInstr = '0;
  logic        cmdValid, cmdIsWrite, done;
  logic [3:0]  curAddrMode, curDataMode, curRwMode;
  logic [1:0]  curRwSub;
  logic [2:0]  curVictimMode, curVictimSel;
  logic [4:0]  curVictimDelay;

  always #2 clk = ~clk;

  mem_traffic_sequencer u_dut (.*);

  int checks = 0, fails = 0;
  int tAddr[32], tRw[32], tSub[32], tIter[32], tN[32], tM[32], tNext[32];
  int dAddr, dRw, dSub, dIter, dN, dM, dNext;
  int qV[$], qT[$], qA[$], qR[$];
  string qTag[$];
  int anyW, anyR;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  task automatic setFields(int addr, int rw, int sub, int iter, int n, int m, int nxt);
    inAddrMode = 4'(addr); inDataMode = 4'd2; inRwMode = 4'(rw); inRwSub = 2'(sub);
    inVictimMode = 3'd1; inVictimDelay = 5'd3; inVictimSel = 3'd2;
    inIterCount = 32'(iter); inBurstN = 32'(n); inNopM = 10'(m); inNextInstr = 6'(nxt);
  endtask

  // R2: level-sensitive table write while idle
  task automatic prog(int idx, int addr, int rw, int sub, int iter, int n, int m, int nxt);
    setFields(addr, rw, sub, iter, n, m, nxt);
    progIdx = 5'(idx); progEn = 1'b1;
    @(negedge clk);
    progEn = 1'b0;
    tAddr[idx] = addr; tRw[idx] = rw; tSub[idx] = sub; tIter[idx] = iter;
    tN[idx] = n; tM[idx] = m; tNext[idx] = nxt;
  endtask

  task automatic push(int v, int t, int a, int r, string tag);
    qV.push_back(v); qT.push_back(t); qA.push_back(a); qR.push_back(r); qTag.push_back(tag);
  endtask

  // behavioural expectation: per-cycle list; type 0 rd, 1 wr, 2 either, 3 fetch
  task automatic build(bit direct, int foreverReads);
    int ptr = 0;
    qV.delete(); qT.delete(); qA.delete(); qR.delete(); qTag.delete();
    for (int g = 0; g < 40; g++) begin
      int a, rw, sub, iter, n, m, nxt;
      int types[$];
      string tag;
      if (direct) begin
        a = dAddr; rw = dRw; sub = dSub; iter = dIter; n = dN; m = dM; nxt = dNext;
      end else begin
        a = tAddr[ptr]; rw = tRw[ptr]; sub = tSub[ptr]; iter = tIter[ptr];
        n = tN[ptr]; m = tM[ptr]; nxt = tNext[ptr];
      end
      push(0, 3, 0, 0, direct ? "R11" : "R3");
      if (rw > 3 || iter == 0) break; // R10
      if (rw == 0) begin tag = "R4"; repeat (iter) types.push_back(0); end
      else if (rw == 1) begin tag = "R4"; repeat (iter) types.push_back(1); end
      else if (rw == 2 && sub == 1) begin tag = "R6"; repeat (2*iter) types.push_back(2); end
      else if (rw == 2) begin
        tag = "R5"; repeat (iter) types.push_back(1); repeat (iter) types.push_back(0);
      end else begin
        tag = "R7"; repeat (iter) types.push_back(1); repeat (foreverReads) types.push_back(0);
      end
      for (int k = 0; k < types.size(); k++) begin
        push(1, types[k], a, rw, tag);
        if ((rw == 3 || k + 1 < types.size()) && n != 0 && (k + 1) % n == 0)
          repeat (m) push(0, 0, 0, 0, "R8");
      end
      if (rw == 3 || nxt >= 32) break; // R9 exit
      ptr = nxt;
    end
  endtask

  task automatic cmp(int i);
    chk(cmdValid == qV[i][0], qTag[i], $sformatf("cmdValid@%0d", i), cmdValid, qV[i]);
    chk(done == 1'b0, "R3", "done during run", done, 0);
    if (qV[i] == 1 && cmdValid) begin
      if (qT[i] == 2) begin
        if (cmdIsWrite) anyW++; else anyR++;
        chk(anyR <= anyW, "R6", "reads ahead of writes", anyR, anyW);
      end else begin
        chk(cmdIsWrite == qT[i][0], qTag[i], $sformatf("cmdIsWrite@%0d", i), cmdIsWrite, qT[i]);
      end
      chk(curRwMode == 4'(qR[i]), "R12", "curRwMode", curRwMode, qR[i]);
      chk(curAddrMode == 4'(qA[i]), "R12", "curAddrMode", curAddrMode, qA[i]);
    end
  endtask

  task automatic run(bit direct, int pokeAt, bit expectEnd, int foreverReads);
    build(direct, foreverReads);
    directEn = direct;
    anyW = 0; anyR = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < qV.size(); i++) begin
      cmp(i);
      if (i == pokeAt) begin // R2 and R13: ignored while running
        setFields(9, 1, 0, 9, 0, 0, 32);
        progIdx = 5'd6; progEn = 1'b1; start = 1'b1;
      end
      @(negedge clk);
      progEn = 1'b0; start = 1'b0;
    end
    if (expectEnd) begin
      repeat (2) begin
        chk(done == 1'b1, "R9", "done after exit", done, 1);
        chk(cmdValid == 1'b0, "R9", "quiet after exit", cmdValid, 0);
        @(negedge clk);
      end
    end
    chk(anyW == anyR, "R6", "mixed totals equal", anyR, anyW);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmdValid == 1'b0, "R1", "cmdValid in reset", cmdValid, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cmdValid == 1'b0 && done == 1'b0, "R1", "idle after reset", cmdValid, 0);

    // run 1: chain of five, gaps across phases, mixed, reserved mode exit (R10)
    prog(0, 1, 1, 0, 3, 2, 0, 1);   // writes, gap length 0
    prog(1, 2, 0, 0, 4, 2, 3, 2);   // reads, 3 idle after each 2
    prog(2, 3, 2, 0, 3, 4, 1, 3);   // write-then-read, gap after 4th
    prog(3, 4, 2, 1, 5, 0, 5, 4);   // mixed, gaps disabled by N=0
    prog(4, 5, 7, 0, 2, 0, 0, 0);   // reserved mode -> exit
    run(0, -1, 1, 0);

    // run 2: table write and start mid-run are ignored (R2, R13)
    prog(0, 6, 1, 0, 6, 0, 0, 6);
    prog(6, 7, 0, 0, 2, 0, 0, 32);
    run(0, 2, 1, 0);

    // run 3: zero count rejected at fetch (R10)
    prog(0, 8, 0, 0, 0, 0, 0, 1);
    run(0, -1, 1, 0);

    // run 4: direct mode bypasses table (R11), gap every command (R8)
    dAddr = 10; dRw = 1; dSub = 0; dIter = 3; dN = 1; dM = 2; dNext = 33;
    setFields(dAddr, dRw, dSub, dIter, dN, dM, dNext);
    run(1, -1, 1, 0);
    directEn = 1'b0;

    // run 5: write once, read forever until reset (R7)
    prog(0, 11, 3, 0, 2, 5, 1, 32);
    run(0, -1, 0, 14);
    chk(cmdValid == 1'b1 && done == 1'b0, "R7", "still reading", cmdValid, 1);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk(cmdValid == 1'b0 && done == 1'b0, "R1", "reset stops traffic", cmdValid, 0);
    @(negedge clk);
    chk(cmdValid == 1'b0, "R1", "stays idle", cmdValid, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule